// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block is the fixed register set that an operating system uses to handle power events on a PC-style chipset. It keeps a free-running count of an external 3.579545 MHz tick, a status register whose bits latch timer-overflow, global, power-button and real-time-clock events, a matching enable register, and a control register. Together the status and enable registers drive a single level-sensitive system control interrupt (SCI) line.

Software reaches the registers through a small I/O port with a 6-bit offset, a width flag (16-bit or 32-bit access), separate read and write strobes, and read data that arrives one cycle after the read strobe. A separate one-byte command port lets firmware switch the SCI-enable bit on and off with two fixed byte values. A control write that sets the sleep-enable bit with sleep type zero produces a one-cycle soft-off request for the rest of the chip. Event sources and the timer tick arrive as single-cycle input strobes from outside the block.

Top module: `pmgr_evt_top`

## Requirements
- R1: After reset the timer, status, enable and control registers are zero, `rdData` is zero, and `sciLevel` and `offReq` are low.
- R2: The timer count (TMR_W bits, default 24) advances by one on each cycle with `tickEn` high and wraps to zero; a 32-bit read (`ioWide`=1) at offset 0x08 returns the count held in the read cycle, zero-extended so the bits above the count read as zero.
- R3: Status bit 0 (timer overflow) sets on every tick that changes the timer's top bit (bit 23 by default), both on the carry into that bit and on the wrap to zero; once cleared it sets again only at the next such change.
- R4: A high `rtcEvt`, `pwrBtnEvt` or `glbEvt` sets status bit 10, 8 or 5 respectively; only status bits 0, 5, 8 and 10 are implemented and all other status bits read as zero.
- R5: A 16-bit write at offset 0x00 clears each status bit written as 1 and leaves bits written as 0; an event strobe in the same cycle as a clear of its bit leaves that bit set.
- R6: A 16-bit write at offset 0x02 stores all 16 enable bits, and a 16-bit read there returns them.
- R7: `sciLevel` is high exactly when at least one of bits 0, 5, 8 and 10 is set in both status and enable, and follows the registers in the cycle after the write or event that changed them.
- R8: A 16-bit write at offset 0x04 stores the written value in the control register except bit 13 (sleep enable), which always reads 0.
- R9: A control write with bit 13 = 1 and sleep type (bits 11:10) = 00 drives `offReq` high for exactly the one cycle after the write; any other sleep type, or bit 13 = 0, leaves `offReq` low.
- R10: A command-port byte 0xF1 sets control bit 0 (SCI enable) and 0xF0 clears it; other byte values change nothing; a command byte in the same cycle as a control write takes precedence for bit 0.
- R11: A read at offsets other than 0x00, 0x02, 0x04 and 0x08, a 32-bit read of a 16-bit register or a 16-bit read of the timer returns zero; 32-bit writes and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One pulse per period of the 3.579545 MHz timer rate |
| rtcEvt | input | 1 | Real-time-clock alarm event strobe |
| pwrBtnEvt | input | 1 | Power-button event strobe |
| glbEvt | input | 1 | Global event strobe |
| ioAddr | input | 6 | Register offset within the 64-byte window |
| ioWide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioWrData | input | 16 | Write data for 16-bit register writes |
| smiWr | input | 1 | Command-port byte strobe |
| smiData | input | 8 | Command-port byte |
| rdData | output | DATA_W (32) | Read data, valid the cycle after `ioRd`, held until the next read |
| sciLevel | output | 1 | Level-sensitive system control interrupt |
| offReq | output | 1 | One-cycle soft-off request |

## Verification
The embedded properties watch, on every cycle, that the timer steps by exactly one per tick and holds otherwise, that a tick carrying the top bit leaves the overflow status set, that an event strobe always leaves its status bit set even under a simultaneous clear, that the enable command byte always leaves SCI enable set, that zero-selected reads return zero, and that every soft-off pulse traces back to a sleep-type-zero control write at the ports. The bench scenarios are needed for what a single-cycle property cannot show: the full contents of read-back registers after sequences of writes, the gating of the interrupt by the enable mask across set and clear, the overflow recurring only at the next boundary after a clear, ignored writes leaving earlier values untouched, and `offReq` staying low for the non-zero sleep types.

// File: rtl/pmgr_pkg.sv
package pmgr_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned REG_W  = 16;

  // Register offsets inside the 64-byte window
  localparam logic [ADDR_W-1:0] OFS_STS = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_EN  = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TMR = 6'h08;

  // Event bit positions shared by status and enable
  localparam int unsigned BIT_TMR = 0;
  localparam int unsigned BIT_GLB = 5;
  localparam int unsigned BIT_PWR = 8;
  localparam int unsigned BIT_RTC = 10;

  // Control register fields
  localparam int unsigned BIT_SCIEN  = 0;
  localparam int unsigned SLPTYP_LO  = 10;
  localparam int unsigned BIT_SLPEN  = 13;

  // Command-port byte values
  localparam logic [7:0] SMI_ON  = 8'hF1;
  localparam logic [7:0] SMI_OFF = 8'hF0;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_STS,
    SEL_EN,
    SEL_CTL,
    SEL_TMR
  } rdSel_e;

  typedef struct packed {
    logic   rd;
    rdSel_e sel;
    logic   wrSts;
    logic   wrEn;
    logic   wrCtl;
    logic   offHit;
    logic   smiOn;
    logic   smiOff;
  } strobe_t;

endpackage

// File: rtl/pmgr_ctrl.sv
module pmgr_ctrl
  import pmgr_pkg::*;
(
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWide,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [REG_W-1:0]  wrLo,
  input  logic              smiWr,
  input  logic [7:0]        smiData,
  output strobe_t           strb
);

  logic narrow;
  logic hitSts;
  logic hitEn;
  logic hitCtl;
  logic hitTmr;

  assign narrow = !ioWide;
  assign hitSts = (ioAddr == OFS_STS);
  assign hitEn  = (ioAddr == OFS_EN);
  assign hitCtl = (ioAddr == OFS_CTL);
  assign hitTmr = (ioAddr == OFS_TMR);

  always_comb begin
    strb     = '0;
    strb.rd  = ioRd;
    strb.sel = SEL_ZERO;
    if (narrow && hitSts)      strb.sel = SEL_STS;
    else if (narrow && hitEn)  strb.sel = SEL_EN;
    else if (narrow && hitCtl) strb.sel = SEL_CTL;
    else if (ioWide && hitTmr) strb.sel = SEL_TMR;

    // Only 16-bit writes reach the registers
    strb.wrSts  = ioWr && narrow && hitSts;
    strb.wrEn   = ioWr && narrow && hitEn;
    strb.wrCtl  = ioWr && narrow && hitCtl;
    strb.offHit = strb.wrCtl && wrLo[BIT_SLPEN] && (wrLo[SLPTYP_LO +: 2] == 2'b00);

    strb.smiOn  = smiWr && (smiData == SMI_ON);
    strb.smiOff = smiWr && (smiData == SMI_OFF);
  end

endmodule

// File: rtl/pmgr_dp.sv
module pmgr_dp
  import pmgr_pkg::*;
#(
  parameter int unsigned TMR_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rtcEvt,
  input  logic              pwrBtnEvt,
  input  logic              glbEvt,
  input  strobe_t           strb,
  input  logic [REG_W-1:0]  wrLo,
  output logic [DATA_W-1:0] rdData,
  output logic              sciLevel,
  output logic              offReq
);

  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GLB) | (1 << BIT_PWR) | (1 << BIT_RTC));
  localparam logic [REG_W-1:0] SLPEN_MASK = REG_W'(1) << BIT_SLPEN;
  localparam logic [TMR_W-1:0] PRE_CARRY  = {1'b0, {(TMR_W-1){1'b1}}};

  logic [TMR_W-1:0] tmrCnt;
  logic [TMR_W-1:0] tmrNext;
  logic             tmrTop;
  logic [REG_W-1:0] sts;
  logic [REG_W-1:0] stsNext;
  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] en;
  logic [REG_W-1:0] ctl;
  logic [REG_W-1:0] ctlNext;

  // Free-running timer; overflow event whenever a tick flips the top bit
  assign tmrNext = tmrCnt + 1'b1;
  assign tmrTop  = tickEn && (tmrNext[TMR_W-1] != tmrCnt[TMR_W-1]);

  always_ff @(posedge clk) begin
    if (!rstN)       tmrCnt <= '0;
    else if (tickEn) tmrCnt <= tmrNext;
  end

  // Status: write-one-to-clear, a set in the same cycle wins
  always_comb begin
    setVec          = '0;
    setVec[BIT_TMR] = tmrTop;
    setVec[BIT_GLB] = glbEvt;
    setVec[BIT_PWR] = pwrBtnEvt;
    setVec[BIT_RTC] = rtcEvt;
    stsNext = strb.wrSts ? (sts & ~wrLo) : sts;
    stsNext = (stsNext | setVec) & EVT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sts <= '0;
    else       sts <= stsNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          en <= '0;
    else if (strb.wrEn) en <= wrLo;
  end

  // Control: sleep-enable is never kept; command byte overrides bit 0
  always_comb begin
    ctlNext = strb.wrCtl ? (wrLo & ~SLPEN_MASK) : ctl;
    if (strb.smiOn)       ctlNext[BIT_SCIEN] = 1'b1;
    else if (strb.smiOff) ctlNext[BIT_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctl <= '0;
    else       ctl <= ctlNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) offReq <= 1'b0;
    else       offReq <= strb.offHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rd) begin
      case (strb.sel)
        SEL_STS: rdData <= DATA_W'(sts);
        SEL_EN:  rdData <= DATA_W'(en);
        SEL_CTL: rdData <= DATA_W'(ctl);
        SEL_TMR: rdData <= DATA_W'(tmrCnt);
        default: rdData <= '0;
      endcase
    end
  end

  assign sciLevel = |(sts & en & EVT_MASK);

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> tmrCnt == TMR_W'($past(tmrCnt) + 1'b1));

  assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tmrCnt));

  assert_top_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && tmrCnt == PRE_CARRY) |=> sts[BIT_TMR]);

  assert_rtc_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    rtcEvt |=> sts[BIT_RTC]);

  assert_pwr_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwrBtnEvt && strb.wrSts) |=> sts[BIT_PWR]);

  assert_smi_on_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.smiOn |=> ctl[BIT_SCIEN]);

  assert_zero_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sel == SEL_ZERO) |=> rdData == '0);

endmodule

// File: rtl/pmgr_evt_top.sv
module pmgr_evt_top
  import pmgr_pkg::*;
#(
  parameter int unsigned TMR_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rtcEvt,
  input  logic              pwrBtnEvt,
  input  logic              glbEvt,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWide,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [REG_W-1:0]  ioWrData,
  input  logic              smiWr,
  input  logic [7:0]        smiData,
  output logic [DATA_W-1:0] rdData,
  output logic              sciLevel,
  output logic              offReq
);

  strobe_t strb;

  pmgr_ctrl u_ctrl (
    .ioAddr  (ioAddr),
    .ioWide  (ioWide),
    .ioWr    (ioWr),
    .ioRd    (ioRd),
    .wrLo    (ioWrData),
    .smiWr   (smiWr),
    .smiData (smiData),
    .strb    (strb)
  );

  pmgr_dp #(
    .TMR_W  (TMR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .rtcEvt    (rtcEvt),
    .pwrBtnEvt (pwrBtnEvt),
    .glbEvt    (glbEvt),
    .strb      (strb),
    .wrLo      (ioWrData),
    .rdData    (rdData),
    .sciLevel  (sciLevel),
    .offReq    (offReq)
  );

  // Every soft-off pulse must come from a sleep-type-zero control write
  assert_off_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    offReq |-> $past(ioWr && !ioWide && ioAddr == OFS_CTL &&
                     ioWrData[BIT_SLPEN] && ioWrData[SLPTYP_LO +: 2] == 2'b00));

endmodule

// File: tb/pmgr_evt_top_tb.sv
`timescale 1ns/1ps
module pmgr_evt_top_tb;

  localparam int TW = 8;   // short timer so overflows are reachable
  localparam int DW = 32;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_SMI = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic        wide;
    logic [15:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [0:NV-1] = '{
    '{OP_WR,  6'h02, 1'b0, 16'h0521, 32'h0,      4'd6 },  // R6 enable write
    '{OP_RD,  6'h02, 1'b0, 16'h0,    32'h0521,   4'd6 },  // R6
    '{OP_RD,  6'h00, 1'b0, 16'h0,    32'h0,      4'd4 },  // R4 no events yet
    '{OP_WR,  6'h04, 1'b0, 16'hFFFF, 32'h0,      4'd8 },  // R8 type 11
    '{OP_RD,  6'h04, 1'b0, 16'h0,    32'hDFFF,   4'd8 },  // R8 bit 13 dropped
    '{OP_SMI, 6'h00, 1'b0, 16'h00F0, 32'h0,      4'd10},  // R10 off byte
    '{OP_RD,  6'h04, 1'b0, 16'h0,    32'hDFFE,   4'd10},  // R10
    '{OP_SMI, 6'h00, 1'b0, 16'h0055, 32'h0,      4'd10},  // R10 other byte
    '{OP_RD,  6'h04, 1'b0, 16'h0,    32'hDFFE,   4'd10},  // R10 unchanged
    '{OP_SMI, 6'h00, 1'b0, 16'h00F1, 32'h0,      4'd10},  // R10 on byte
    '{OP_RD,  6'h04, 1'b0, 16'h0,    32'hDFFF,   4'd10},  // R10
    '{OP_WR,  6'h04, 1'b0, 16'h0000, 32'h0,      4'd8 },  // R8
    '{OP_RD,  6'h04, 1'b0, 16'h0,    32'h0,      4'd8 },  // R8
    '{OP_WR,  6'h02, 1'b1, 16'h0000, 32'h0,      4'd11},  // R11 32-bit write ignored
    '{OP_RD,  6'h02, 1'b0, 16'h0,    32'h0521,   4'd11},  // R11
    '{OP_WR,  6'h06, 1'b0, 16'hFFFF, 32'h0,      4'd11},  // R11 unused offset
    '{OP_RD,  6'h06, 1'b0, 16'h0,    32'h0,      4'd11},  // R11
    '{OP_RD,  6'h08, 1'b0, 16'h0,    32'h0,      4'd11},  // R11 narrow timer read
    '{OP_RD,  6'h00, 1'b1, 16'h0,    32'h0,      4'd11},  // R11 wide status read
    '{OP_RD,  6'h08, 1'b1, 16'h0,    32'h0,      4'd2 }   // R2 timer at zero
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic          rtcEvt = 1'b0;
  logic          pwrBtnEvt = 1'b0;
  logic          glbEvt = 1'b0;
  logic [5:0]    ioAddr = '0;
  logic          ioWide = 1'b0;
  logic          ioWr = 1'b0;
  logic          ioRd = 1'b0;
  logic [15:0]   ioWrData = '0;
  logic          smiWr = 1'b0;
  logic [7:0]    smiData = '0;
  logic [DW-1:0] rdData;
  logic          sciLevel;
  logic          offReq;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  pmgr_evt_top #(.TMR_W(TW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rtcEvt(rtcEvt),
    .pwrBtnEvt(pwrBtnEvt), .glbEvt(glbEvt), .ioAddr(ioAddr),
    .ioWide(ioWide), .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData),
    .smiWr(smiWr), .smiData(smiData), .rdData(rdData),
    .sciLevel(sciLevel), .offReq(offReq)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWr(input logic [5:0] a, input logic w, input logic [15:0] d);
    ioAddr = a; ioWide = w; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic doRd(input logic [5:0] a, input logic w, output logic [31:0] d);
    ioAddr = a; ioWide = w; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    d = rdData;
  endtask

  task automatic doSmi(input logic [7:0] b);
    smiData = b; smiWr = 1'b1;
    @(negedge clk);
    smiWr = 1'b0;
  endtask

  task automatic doTick(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(1, rdData, 32'h0);
    chk(1, {31'h0, sciLevel}, 32'h0);
    chk(1, {31'h0, offReq}, 32'h0);
    doRd(6'h00, 1'b0, rv); chk(1, rv, 32'h0);
    doRd(6'h02, 1'b0, rv); chk(1, rv, 32'h0);
    doRd(6'h04, 1'b0, rv); chk(1, rv, 32'h0);
    doRd(6'h08, 1'b1, rv); chk(1, rv, 32'h0);

    // Table of register accesses
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:  doWr(VEC[i].addr, VEC[i].wide, VEC[i].data);
        OP_SMI: doSmi(VEC[i].data[7:0]);
        default: begin
          doRd(VEC[i].addr, VEC[i].wide, rv);
          chk(int'(VEC[i].req), rv, VEC[i].exp);
        end
      endcase
    end

    // R4 / R7 events set status and raise SCI through enable 0x0521
    rtcEvt = 1'b1; @(negedge clk); rtcEvt = 1'b0;
    chk(7, {31'h0, sciLevel}, 32'h1);
    doRd(6'h00, 1'b0, rv); chk(4, rv, 32'h0400);
    pwrBtnEvt = 1'b1; glbEvt = 1'b1; @(negedge clk);
    pwrBtnEvt = 1'b0; glbEvt = 1'b0;
    doRd(6'h00, 1'b0, rv); chk(4, rv, 32'h0520);

    // R5 write-one-to-clear and set-wins
    doWr(6'h00, 1'b0, 16'h0400);
    doRd(6'h00, 1'b0, rv); chk(5, rv, 32'h0120);
    ioAddr = 6'h00; ioWide = 1'b0; ioWrData = 16'h0100; ioWr = 1'b1; pwrBtnEvt = 1'b1;
    @(negedge clk);
    ioWr = 1'b0; pwrBtnEvt = 1'b0;
    doRd(6'h00, 1'b0, rv); chk(5, rv, 32'h0120);
    doWr(6'h00, 1'b0, 16'hFFFF);
    doRd(6'h00, 1'b0, rv); chk(5, rv, 32'h0);
    chk(7, {31'h0, sciLevel}, 32'h0);

    // R7 gating by enable
    doWr(6'h02, 1'b0, 16'h0000);
    rtcEvt = 1'b1; @(negedge clk); rtcEvt = 1'b0;
    chk(7, {31'h0, sciLevel}, 32'h0);
    doWr(6'h02, 1'b0, 16'h0400);
    chk(7, {31'h0, sciLevel}, 32'h1);
    doWr(6'h00, 1'b0, 16'h0400);
    chk(7, {31'h0, sciLevel}, 32'h0);

    // R2 / R3 timer count and overflow at the top bit
    doTick(100);
    doRd(6'h08, 1'b1, rv); chk(2, rv, 32'd100);
    doRd(6'h00, 1'b0, rv); chk(3, rv, 32'h0);
    doTick(27);
    doRd(6'h00, 1'b0, rv); chk(3, rv, 32'h0);
    doTick(1);
    doRd(6'h00, 1'b0, rv); chk(3, rv, 32'h0001);
    chk(7, {31'h0, sciLevel}, 32'h0);   // bit 0 not enabled
    doWr(6'h00, 1'b0, 16'h0001);
    doRd(6'h00, 1'b0, rv); chk(3, rv, 32'h0);
    doTick(127);
    doRd(6'h00, 1'b0, rv); chk(3, rv, 32'h0);
    doRd(6'h08, 1'b1, rv); chk(2, rv, 32'd255);
    doTick(1);
    doRd(6'h00, 1'b0, rv); chk(3, rv, 32'h0001);
    doRd(6'h08, 1'b1, rv); chk(2, rv, 32'd0);

    // R9 soft-off pulse for sleep type 0 only
    ioAddr = 6'h04; ioWide = 1'b0; ioWrData = 16'h2000; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
    chk(9, {31'h0, offReq}, 32'h1);
    @(negedge clk);
    chk(9, {31'h0, offReq}, 32'h0);
    doRd(6'h04, 1'b0, rv); chk(8, rv, 32'h0);
    ioWrData = 16'h2400; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
    chk(9, {31'h0, offReq}, 32'h0);
    @(negedge clk);
    chk(9, {31'h0, offReq}, 32'h0);
    doRd(6'h04, 1'b0, rv); chk(8, rv, 32'h0400);

    // R10 command byte beats same-cycle control write
    ioAddr = 6'h04; ioWide = 1'b0; ioWrData = 16'h0000; ioWr = 1'b1;
    smiData = 8'hF1; smiWr = 1'b1;
    @(negedge clk); ioWr = 1'b0; smiWr = 1'b0;
    doRd(6'h04, 1'b0, rv); chk(10, rv, 32'h0001);

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

endmodule